// File: doc/BRIEF.md
# Wormhole Dimension-Order Mesh Router

This block is one switching node of a two-dimensional mesh network-on-chip. It has five ports: one toward each compass neighbour and one to the attached local module. Each port carries fixed-width flits on a valid/ready pair in each direction. A packet is a run of flits. Its opening flit holds the destination column and row, and every later flit follows the path that the opening flit reserved. The node's own column and row come in on input pins, so one design serves every position in the mesh.

Each input holds exactly one flit. When an opening flit reaches the front of an input, the router computes its output from the address alone. It resolves the column first and the row only after the column matches. A per-output round-robin arbiter then grants that output. The output stays tied to the granted input until the closing flit has left, so packets never interleave on a link. There are no virtual channels. Only one switching decision is made per packet.

Top module: `mesh_router`

## Requirements
- R1: Once reset is released and before any flit is offered, every out_valid bit is low and every in_ready bit is high.
- R2: Port indices are 0 local, 1 north, 2 east, 3 south, 4 west. The opening flit carries the destination column in bits [X_W-1:0] and the row in bits [X_W+Y_W-1:X_W]. A column larger than the node's goes east and a smaller one goes west. With the column equal, a larger row goes north and a smaller one south. With both equal, the packet goes to local.
- R3: The flit kind sits in the top two bits. Bit FW-2 set marks an opening flit and bit FW-1 set marks a closing flit: 01 head, 00 body, 10 tail, 11 single. A single-flit packet frees its output in the cycle it leaves, so a head from another input can leave on the next cycle.
- R4: After an input is granted an output, every flit leaving that output comes from that input, in arrival order, until its closing flit has left.
- R5: Among heads waiting for a free output, the winner is the first input index at or after that output's pointer, counting upward with wraparound. When the winner's closing flit leaves, the pointer moves to the winner's index plus one, modulo 5. The pointer resets to 0.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_flit holds its value on the next cycle.
- R7: A head that routes to an output held by another input waits in its buffer until that packet's tail has left.
- R8: in_ready for an input is high exactly when its one-word buffer is empty or the buffered flit leaves in that cycle.
- R9: A flit accepted on a clock edge is offered on its output from the next cycle, provided the output is granted to its input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| my_x | input | X_W | Column of this node |
| my_y | input | Y_W | Row of this node |
| in_valid | input | 5 | Flit offered on each input port |
| in_flit | input | 5*(PAY_W+2) | Input flits, port p at bits [p*FW +: FW] |
| in_ready | output | 5 | Input port can take a flit this cycle |
| out_valid | output | 5 | Flit offered on each output port |
| out_flit | output | 5*(PAY_W+2) | Output flits, port p at bits [p*FW +: FW] |
| out_ready | input | 5 | Downstream accepts the output flit |

## Verification
The routing sweep sends single-flit packets to all sixteen destinations from two node positions, one central and one at a corner. This separates the column-first decision and the local case from any row-first or mirrored mapping. Two contention patterns are used. One starts a long packet on an output before a second head arrives; the other starts several heads in the same cycle with the pointer left mid-range by an earlier round. Together they tell true round-robin from fixed priority and show that a held output is never interleaved. Back-to-back single-flit packets show that a single frees its output at once. Random traffic with random downstream stalls, checked every cycle against a behavioural model, exercises hold-under-backpressure and the one-word buffer's ready timing.

// File: rtl/mesh_pkg.sv
package mesh_pkg;
  localparam int NPORT  = 5;
  localparam int KIND_W = 2;

  localparam int P_LOCAL = 0;
  localparam int P_NORTH = 1;
  localparam int P_EAST  = 2;
  localparam int P_SOUTH = 3;
  localparam int P_WEST  = 4;

  typedef enum logic [KIND_W-1:0] {
    FK_BODY = 2'b00,
    FK_HEAD = 2'b01,
    FK_TAIL = 2'b10,
    FK_SOLO = 2'b11
  } flit_kind_e;

  function automatic logic kind_opens(input logic [KIND_W-1:0] k);
    return k[0];
  endfunction

  function automatic logic kind_closes(input logic [KIND_W-1:0] k);
    return k[1];
  endfunction
endpackage

// File: rtl/rt_inbuf.sv
module rt_inbuf #(
  parameter int FW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [FW-1:0] in_flit,
  output logic          in_ready,
  input  logic          drain,
  output logic          full,
  output logic [FW-1:0] word
);
  // Room when empty, or when the held word leaves this cycle.
  assign in_ready = !full || drain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      word <= '0;
    end else if (in_valid && in_ready) begin
      full <= 1'b1;
      word <= in_flit;
    end else if (drain) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/rt_route.sv
module rt_route #(
  parameter int X_W = 2,
  parameter int Y_W = 2,
  parameter int SW  = 3
) (
  input  logic [X_W-1:0] dst_x,
  input  logic [Y_W-1:0] dst_y,
  input  logic [X_W-1:0] my_x,
  input  logic [Y_W-1:0] my_y,
  output logic [SW-1:0]  dir
);
  import mesh_pkg::*;

  // Column first; row only once the column matches.
  function automatic logic [SW-1:0] xy_dir(
    input logic [X_W-1:0] dx, input logic [Y_W-1:0] dy,
    input logic [X_W-1:0] mx, input logic [Y_W-1:0] my);
    if (dx > mx) return SW'(P_EAST);
    if (dx < mx) return SW'(P_WEST);
    if (dy > my) return SW'(P_NORTH);
    if (dy < my) return SW'(P_SOUTH);
    return SW'(P_LOCAL);
  endfunction

  assign dir = xy_dir(dst_x, dst_y, my_x, my_y);
endmodule

// File: rtl/rt_outport.sv
module rt_outport #(
  parameter int N  = 5,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  src_full,
  input  logic [N-1:0]  src_last,
  input  logic          out_ready,
  output logic          out_valid,
  output logic          fire,
  output logic          locked,
  output logic [SW-1:0] sel,
  output logic [SW-1:0] owner
);
  function automatic logic [SW-1:0] step(input logic [SW-1:0] v);
    if (int'(v) >= N - 1) return '0;
    return v + SW'(1);
  endfunction

  function automatic logic [SW-1:0] rr_pick(input logic [N-1:0] r,
                                            input logic [SW-1:0] start);
    logic [SW-1:0] idx;
    logic [SW-1:0] win;
    logic          hit;
    idx = start;
    win = start;
    hit = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!hit && r[idx]) begin
        win = idx;
        hit = 1'b1;
      end
      idx = step(idx);
    end
    return win;
  endfunction

  logic [SW-1:0] ptr;
  logic [SW-1:0] pick;
  logic          any_req;
  logic          closing;

  assign pick      = rr_pick(req, ptr);
  assign any_req   = |req;
  assign sel       = locked ? owner : pick;
  assign out_valid = locked ? src_full[owner] : any_req;
  assign fire      = out_valid && out_ready;
  assign closing   = src_last[sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b0;
      owner  <= '0;
      ptr    <= '0;
    end else if (!locked) begin
      if (any_req) begin
        if (fire && closing) begin
          ptr <= step(pick);
        end else begin
          locked <= 1'b1;
          owner  <= pick;
        end
      end
    end else if (fire && closing) begin
      locked <= 1'b0;
      ptr    <= step(owner);
    end
  end
endmodule

// File: rtl/mesh_router.sv
module mesh_router
  import mesh_pkg::*;
#(
  parameter int X_W   = 2,
  parameter int Y_W   = 2,
  parameter int PAY_W = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [X_W-1:0]                   my_x,
  input  logic [Y_W-1:0]                   my_y,
  input  logic [NPORT-1:0]                 in_valid,
  input  logic [NPORT*(PAY_W+KIND_W)-1:0]  in_flit,
  output logic [NPORT-1:0]                 in_ready,
  output logic [NPORT-1:0]                 out_valid,
  output logic [NPORT*(PAY_W+KIND_W)-1:0]  out_flit,
  input  logic [NPORT-1:0]                 out_ready
);
  localparam int N  = NPORT;
  localparam int FW = PAY_W + KIND_W;
  localparam int SW = $clog2(N);

  logic [FW-1:0]   word [N];
  logic [N-1:0]    full;
  logic [N-1:0]    drain;
  logic [N-1:0]    is_open;
  logic [N-1:0]    is_close;
  logic [SW-1:0]   dir [N];
  logic [N-1:0]    req_vec [N];

  // Events brought out for the checker.
  logic [N-1:0]    fire_v;
  logic [N-1:0]    lock_v;
  logic [N*SW-1:0] owner_flat;
  logic [N*SW-1:0] sel_flat;

  for (genvar i = 0; i < N; i++) begin : g_in
    rt_inbuf #(.FW(FW)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid[i]),
      .in_flit  (in_flit[i*FW +: FW]),
      .in_ready (in_ready[i]),
      .drain    (drain[i]),
      .full     (full[i]),
      .word     (word[i])
    );

    rt_route #(.X_W(X_W), .Y_W(Y_W), .SW(SW)) u_route (
      .dst_x (word[i][X_W-1:0]),
      .dst_y (word[i][X_W+Y_W-1:X_W]),
      .my_x  (my_x),
      .my_y  (my_y),
      .dir   (dir[i])
    );

    assign is_open[i]  = kind_opens(word[i][FW-1:FW-KIND_W]);
    assign is_close[i] = kind_closes(word[i][FW-1:FW-KIND_W]);
    // Only a waiting head asks for an output; later flits ride the lock.
    assign req_vec[i]  = (full[i] && is_open[i]) ? (N'(1) << dir[i]) : '0;
  end

  for (genvar o = 0; o < N; o++) begin : g_out
    logic [N-1:0]  req_o;
    logic [SW-1:0] sel_o;

    always_comb begin
      for (int i = 0; i < N; i++) req_o[i] = req_vec[i][o];
    end

    rt_outport #(.N(N), .SW(SW)) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req_o),
      .src_full  (full),
      .src_last  (is_close),
      .out_ready (out_ready[o]),
      .out_valid (out_valid[o]),
      .fire      (fire_v[o]),
      .locked    (lock_v[o]),
      .sel       (sel_o),
      .owner     (owner_flat[o*SW +: SW])
    );

    assign sel_flat[o*SW +: SW] = sel_o;
    assign out_flit[o*FW +: FW] = word[sel_o];
  end

  // An input drains when the output it feeds fires.
  always_comb begin
    for (int i = 0; i < N; i++) begin
      drain[i] = 1'b0;
      for (int o = 0; o < N; o++) begin
        if (fire_v[o] && (sel_flat[o*SW +: SW] == SW'(i))) drain[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mesh_router_chk.sv
module mesh_router_chk #(
  parameter int N   = 5,
  parameter int FW  = 18,
  parameter int X_W = 2,
  parameter int Y_W = 2,
  parameter int SW  = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [X_W-1:0] my_x,
  input logic [Y_W-1:0] my_y,
  input logic [N-1:0]  out_valid,
  input logic [N-1:0]  out_ready,
  input logic [N*FW-1:0] out_flit,
  input logic [N-1:0]  fire,
  input logic [N-1:0]  locked,
  input logic [N*SW-1:0] owner,
  input logic [N-1:0]  drain
);
  localparam int LOC = 0;
  localparam int EAS = 2;

  for (genvar p = 0; p < N; p++) begin : g_p
    // R6
    hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[p] && !out_ready[p] |=> out_valid[p] && $stable(out_flit[p*FW +: FW]));

    // R4
    owner_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked[p] && !(fire[p] && out_flit[p*FW + FW - 1]) |=> locked[p] && $stable(owner[p*SW +: SW]));
  end

  // R8
  drain_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_valid & out_ready) == $countones(drain));

  // R2
  local_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[LOC] && out_flit[LOC*FW + FW - 2] |->
      out_flit[LOC*FW +: X_W] == my_x && out_flit[LOC*FW + X_W +: Y_W] == my_y);

  // R2
  east_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[EAS] && out_flit[EAS*FW + FW - 2] |-> out_flit[EAS*FW +: X_W] > my_x);
endmodule

bind mesh_router mesh_router_chk #(
  .N(N), .FW(FW), .X_W(X_W), .Y_W(Y_W), .SW(SW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .my_x      (my_x),
  .my_y      (my_y),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_flit  (out_flit),
  .fire      (fire_v),
  .locked    (lock_v),
  .owner     (owner_flat),
  .drain     (drain)
);

// File: tb/test_mesh_router.sv
`timescale 1ns/1ps
module test_mesh_router;
  localparam int XW = 2;
  localparam int YW = 2;
  localparam int PW = 16;
  localparam int N  = 5;
  localparam int FW = PW + 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [XW-1:0]   my_x;
  logic [YW-1:0]   my_y;
  logic [N-1:0]    in_valid, in_ready, out_valid, out_ready;
  logic [N*FW-1:0] in_flit, out_flit;

  always #2.5 clk = ~clk;

  mesh_router #(.X_W(XW), .Y_W(YW), .PAY_W(PW)) i_mesh_router (
    .clk(clk), .rst_n(rst_n), .my_x(my_x), .my_y(my_y),
    .in_valid(in_valid), .in_flit(in_flit), .in_ready(in_ready),
    .out_valid(out_valid), .out_flit(out_flit), .out_ready(out_ready)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [FW-1:0] sq  [N][$];   // flits still to offer per input
  logic [FW-1:0] acc [N][$];   // model of each one-word buffer
  int cur [N];                 // input holding each output, -1 if free
  int ptr [N];
  bit hold [N];
  logic [FW-1:0] hold_flit [N];
  bit run = 1'b0;
  int rmode = 0;
  int cyc = 0;
  int pkt_id = 0;
  int east_src [$];
  int east_cyc [$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int ref_dir(input int dx, input int dy, input int mx, input int my);
    if (dx != mx) return (dx > mx) ? 2 : 4;
    if (dy != my) return (dy > my) ? 1 : 3;
    return 0;
  endfunction

  task automatic make_pkt(input int src, input int dx, input int dy, input int len);
    for (int f = 0; f < len; f++) begin
      logic [1:0]  kind;
      logic [15:0] pay;
      logic [3:0]  id4;
      logic [2:0]  s3;
      id4 = pkt_id[3:0];
      s3  = src[2:0];
      if (len == 1) kind = 2'b11;
      else if (f == 0) kind = 2'b01;
      else if (f == len - 1) kind = 2'b10;
      else kind = 2'b00;
      if (f == 0) pay = {id4, 1'b0, s3, 4'h0, dy[1:0], dx[1:0]};
      else pay = {id4, 1'b1, s3, f[7:0]};
      sq[src].push_back({kind, pay});
    end
    pkt_id++;
  endtask

  function automatic bit idle();
    for (int i = 0; i < N; i++)
      if (sq[i].size() != 0 || acc[i].size() != 0 || cur[i] >= 0) return 1'b0;
    return 1'b1;
  endfunction

  task automatic wait_idle();
    int t;
    t = 0;
    while (!idle() && t < 20000) begin
      @(posedge clk);
      t++;
    end
    repeat (2) @(posedge clk);
    chk(idle(), "watchdog idle", 32'(t), 32'(0));
  endtask

  // Drive on the falling edge, sample just before the rising edge.
  always @(negedge clk) begin
    if (run) begin
      for (int i = 0; i < N; i++) begin
        in_valid[i] = (sq[i].size() != 0);
        in_flit[i*FW +: FW] = (sq[i].size() != 0) ? sq[i][0] : '0;
        out_ready[i] = (rmode == 0) ? 1'b1 : (($urandom % 4) != 0);
      end
      #2;
      begin
        bit drained [N];
        cyc++;
        // R5: grant free outputs round-robin among waiting heads
        for (int o = 0; o < N; o++) begin
          if (cur[o] < 0) begin
            for (int k = 0; k < N; k++) begin
              int i;
              i = (ptr[o] + k) % N;
              if (cur[o] < 0 && acc[i].size() != 0 && acc[i][0][FW-2] &&
                  ref_dir(int'(acc[i][0][1:0]), int'(acc[i][0][3:2]), int'(my_x), int'(my_y)) == o)
                cur[o] = i;
            end
          end
        end
        for (int i = 0; i < N; i++) drained[i] = 1'b0;
        for (int o = 0; o < N; o++) begin
          bit expv;
          logic [FW-1:0] f;
          expv = (cur[o] >= 0) && (acc[(cur[o] < 0) ? 0 : cur[o]].size() != 0);
          // R2, R7, R9: valid on the routed, granted output only
          chk(out_valid[o] == expv, $sformatf("R2 R7 R9 out_valid port %0d", o), 32'(out_valid[o]), 32'(expv));
          if (expv && out_valid[o]) begin
            // R4: flit belongs to the holder, in order
            chk(out_flit[o*FW +: FW] == acc[cur[o]][0], $sformatf("R4 flit port %0d", o),
                32'(out_flit[o*FW +: FW]), 32'(acc[cur[o]][0]));
          end
          if (hold[o]) begin
            // R6: stalled offer held
            chk(out_valid[o] && out_flit[o*FW +: FW] == hold_flit[o], $sformatf("R6 hold port %0d", o),
                32'(out_flit[o*FW +: FW]), 32'(hold_flit[o]));
          end
          hold[o] = out_valid[o] && !out_ready[o];
          hold_flit[o] = out_flit[o*FW +: FW];
          if (expv && out_valid[o] && out_ready[o]) begin
            int c;
            c = cur[o];
            f = acc[c].pop_front();
            drained[c] = 1'b1;
            if (o == 2) begin
              east_cyc.push_back(cyc);
              if (f[FW-2]) east_src.push_back(int'(f[10:8]));
            end
            if (f[FW-1]) begin
              ptr[o] = (c + 1) % N;
              cur[o] = -1;
            end
          end
        end
        for (int i = 0; i < N; i++) begin
          bit er;
          er = (acc[i].size() == 0) || drained[i];
          // R8: one-word buffer ready rule
          chk(in_ready[i] == er, $sformatf("R8 in_ready port %0d", i), 32'(in_ready[i]), 32'(er));
          if (in_valid[i] && in_ready[i]) begin
            acc[i].push_back(in_flit[i*FW +: FW]);
            void'(sq[i].pop_front());
          end
        end
      end
    end
  end

  initial begin
    #750000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    my_x = 2'd1;
    my_y = 2'd1;
    in_valid = '0;
    in_flit = '0;
    out_ready = '0;
    for (int i = 0; i < N; i++) begin
      cur[i] = -1;
      ptr[i] = 0;
      hold[i] = 1'b0;
      hold_flit[i] = '0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1: quiet outputs, all inputs ready
    chk(out_valid == '0, "R1 out_valid after reset", 32'(out_valid), 32'(0));
    chk(in_ready == '1, "R1 in_ready after reset", 32'(in_ready), 32'h1f);
    run = 1'b1;

    // R2: every destination from a central node, then from a corner
    @(posedge clk);
    for (int dy = 0; dy < 4; dy++)
      for (int dx = 0; dx < 4; dx++) make_pkt(0, dx, dy, 1);
    wait_idle();
    my_x = 2'd3;
    my_y = 2'd0;
    @(posedge clk);
    for (int dy = 0; dy < 4; dy++)
      for (int dx = 0; dx < 4; dx++) begin
        make_pkt(1, dx, dy, 1);
        make_pkt(4, dx, dy, 2);
      end
    wait_idle();
    my_x = 2'd1;
    my_y = 2'd1;
    for (int o = 0; o < N; o++) ptr[o] = ptr[o];

    // R7: a head waits while east is held by a longer packet
    @(posedge clk);
    east_src.delete();
    make_pkt(1, 3, 1, 5);
    repeat (2) @(posedge clk);
    make_pkt(4, 2, 2, 3);
    wait_idle();
    chk(east_src.size() == 2 && east_src[0] == 1 && east_src[1] == 4, "R7 east order",
        32'(east_src.size() > 1 ? east_src[1] : -1), 32'(4));

    // R5: rotation from a mid-range pointer
    @(posedge clk);
    east_src.delete();
    make_pkt(1, 3, 0, 2);
    make_pkt(3, 3, 3, 2);
    wait_idle();
    chk(east_src.size() == 2 && east_src[0] == 1 && east_src[1] == 3, "R5 first round",
        32'(east_src.size() > 0 ? east_src[0] : -1), 32'(1));
    @(posedge clk);
    east_src.delete();
    make_pkt(1, 3, 0, 2);
    make_pkt(3, 3, 3, 2);
    make_pkt(4, 2, 1, 2);
    wait_idle();
    chk(east_src.size() == 3 && east_src[0] == 4 && east_src[1] == 1 && east_src[2] == 3,
        "R5 rotated round", 32'(east_src.size() > 0 ? east_src[0] : -1), 32'(4));

    // R3: single-flit packets release east at once
    @(posedge clk);
    east_cyc.delete();
    make_pkt(1, 2, 1, 1);
    make_pkt(1, 2, 1, 1);
    make_pkt(3, 2, 1, 1);
    make_pkt(3, 2, 1, 1);
    wait_idle();
    chk(east_cyc.size() == 4 && east_cyc[3] - east_cyc[0] == 3, "R3 back-to-back singles",
        32'(east_cyc.size() == 4 ? east_cyc[3] - east_cyc[0] : -1), 32'(3));

    // R6: random traffic under random downstream stalls
    rmode = 1;
    @(posedge clk);
    for (int n = 0; n < 250; n++) begin
      make_pkt(int'($urandom % 5), int'($urandom % 4), int'($urandom % 4), 1 + int'($urandom % 4));
      if (($urandom % 3) == 0) @(posedge clk);
    end
    wait_idle();
    rmode = 0;

    run = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule